// File: doc/BRIEF.md
# Diagnostic Threshold Flag Generator

This block watches five live 16-bit diagnostic readings of an optical transceiver: module temperature, supply voltage, laser bias current, transmitted optical power and received optical power. Each reading arrives on a packed measurement bus, with its high byte above its low byte. Each reading is compared against four host-programmed limits: an upper and a lower limit at the alarm tier, and an upper and a lower limit at the warning tier.

A comparison is taken only when the update strobe is high. Any limit crossing latches a flag bit, and the bit holds until the host pulses the clear input. The flags are presented as two flag words, one per severity tier, so that any number of conditions can be shown together. A single interrupt line is raised while any flag is held.

Converting raw sensor samples and applying calibration arithmetic are done elsewhere. This block sees only finished readings.

Top module: `dmon_flag_gen`

## Requirements
- R1: An upper flag sets only when the reading is strictly greater than its upper limit. A reading equal to the limit sets nothing.
- R2: A lower flag sets only when the reading is strictly less than its lower limit. A reading equal to the limit sets nothing.
- R3: The alarm and warning tiers are evaluated independently. A reading between the warning and alarm limits sets only the warning flag. A reading beyond the alarm limit sets both flags.
- R4: Channel 0 (temperature) is compared as signed two's complement. Channels 1 to 4 are compared as unsigned. For example, 16'hFFF5 is -11 on channel 0 and 65525 on channel 4.
- R5: Readings presented while the update strobe is low set no flag.
- R6: Flags are sticky. A set flag stays set after the reading returns within limits, including across further strobes.
- R7: A clear pulse resets every flag in both tiers. If a clear coincides with a strobe that violates a limit, that flag is set after the edge.
- R8: The interrupt output is high exactly when at least one flag bit in either tier is set.
- R9: After reset, every flag and the interrupt are low.
- R10: Flag layout within each tier word: bit 2k is the upper flag of channel k and bit 2k+1 is its lower flag. The channel order is temperature=0, supply=1, bias=2, transmit power=3, receive power=4. Several bits may be set at the same time. A flag updates on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_stb_i | input | 1 | Update strobe; readings are compared on this cycle |
| meas_i | input | 80 | Readings; channel k in bits [16k+15:16k], high byte first |
| thr_alm_hi_i | input | 80 | Upper alarm limits, same packing |
| thr_alm_lo_i | input | 80 | Lower alarm limits |
| thr_wrn_hi_i | input | 80 | Upper warning limits |
| thr_wrn_lo_i | input | 80 | Lower warning limits |
| flag_clr_i | input | 1 | Host clear pulse for all flags |
| alm_flags_o | output | 10 | Alarm-tier flag word |
| wrn_flags_o | output | 10 | Warning-tier flag word |
| irq_o | output | 1 | Summary interrupt |

## Verification
Readings are placed exactly on a limit, one count past it, and in the band between the warning and alarm limits. These patterns separate a strict comparison from an inclusive one and show whether the two tiers are kept apart. A temperature reading with its top bit set, and a receive-power reading of all ones, show whether each channel uses the correct signed or unsigned interpretation. Out-of-range readings are also applied without the strobe, a reading is returned to range, and a clear is issued in the same cycle as a violation. These show gating, stickiness and the precedence of a new violation over a clear. A behavioural model is compared with both flag words and the interrupt on every clock.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
   localparam int DEF_NUM_CH = 5;
   localparam int DEF_VAL_W  = 16;
   // bit k set: channel k is compared as two's complement
   localparam logic [DEF_NUM_CH-1:0] DEF_SIGNED_MASK = 5'b00001;

   typedef enum int {
      CH_TEMP = 0,
      CH_SUPPLY = 1,
      CH_BIAS = 2,
      CH_TXPWR = 3,
      CH_RXPWR = 4
   } dmon_chan_e;

   // position of a flag inside a tier word
   function automatic int flag_pos(input int ch, input bit is_lower);
      return 2 * ch + (is_lower ? 1 : 0);
   endfunction
endpackage

// File: rtl/dmon_cmp.sv
module dmon_cmp #(
   parameter int VAL_W = 16,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [VAL_W-1:0] val_i,
   input  logic [VAL_W-1:0] hi_lim_i,
   input  logic [VAL_W-1:0] lo_lim_i,
   output logic             above_o,
   output logic             below_o
);
   if (VAL_W < 2) begin : g_bad_width
      $error("dmon_cmp: VAL_W must be at least 2");
   end

   if (IS_SIGNED) begin : g_signed
      always_comb begin
         above_o = $signed(val_i) > $signed(hi_lim_i);
         below_o = $signed(val_i) < $signed(lo_lim_i);
      end
   end else begin : g_unsigned
      always_comb begin
         above_o = val_i > hi_lim_i;
         below_o = val_i < lo_lim_i;
      end
   end
endmodule

// File: rtl/dmon_chan.sv
module dmon_chan #(
   parameter int VAL_W = 16,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [VAL_W-1:0] val_i,
   input  logic [VAL_W-1:0] alm_hi_i,
   input  logic [VAL_W-1:0] alm_lo_i,
   input  logic [VAL_W-1:0] wrn_hi_i,
   input  logic [VAL_W-1:0] wrn_lo_i,
   output logic [1:0]       alm_o,   // [0] upper, [1] lower
   output logic [1:0]       wrn_o
);
   logic alm_up, alm_dn, wrn_up, wrn_dn;

   dmon_cmp #(.VAL_W(VAL_W), .IS_SIGNED(IS_SIGNED)) u_alm (
      .val_i(val_i), .hi_lim_i(alm_hi_i), .lo_lim_i(alm_lo_i),
      .above_o(alm_up), .below_o(alm_dn)
   );

   dmon_cmp #(.VAL_W(VAL_W), .IS_SIGNED(IS_SIGNED)) u_wrn (
      .val_i(val_i), .hi_lim_i(wrn_hi_i), .lo_lim_i(wrn_lo_i),
      .above_o(wrn_up), .below_o(wrn_dn)
   );

   assign alm_o = {alm_dn, alm_up};
   assign wrn_o = {wrn_dn, wrn_up};
endmodule

// File: rtl/dmon_sticky.sv
module dmon_sticky #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         stb_i,
   input  logic         clr_i,
   input  logic [W-1:0] viol_i,
   output logic [W-1:0] flags_o
);
   if (W < 1) begin : g_bad_w
      $error("dmon_sticky: W must be positive");
   end

   logic [W-1:0] keep, hit;

   always_comb begin
      keep = clr_i ? '0 : flags_o;
      hit  = stb_i ? viol_i : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o <= '0;
      else         flags_o <= keep | hit;
   end

   // R1 R2 R7: a strobed violation is set on the next edge, clear or not
   a_r7_hit_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i |=> ((flags_o & $past(viol_i)) == $past(viol_i)));

   // R5: no new bit appears without a strobe
   a_r5_no_stb_no_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_i |=> ((flags_o & ~$past(flags_o)) == '0));

   // R6: without clear, no bit falls
   a_r6_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

   // R7: clear without strobe empties the word
   a_r7_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !stb_i) |=> (flags_o == '0));
endmodule

// File: rtl/dmon_flag_gen.sv
module dmon_flag_gen
   import dmon_pkg::*;
#(
   parameter int NUM_CH = DEF_NUM_CH,
   parameter int VAL_W = DEF_VAL_W,
   parameter logic [NUM_CH-1:0] SIGNED_MASK = DEF_SIGNED_MASK
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    meas_stb_i,
   input  logic [NUM_CH*VAL_W-1:0] meas_i,
   input  logic [NUM_CH*VAL_W-1:0] thr_alm_hi_i,
   input  logic [NUM_CH*VAL_W-1:0] thr_alm_lo_i,
   input  logic [NUM_CH*VAL_W-1:0] thr_wrn_hi_i,
   input  logic [NUM_CH*VAL_W-1:0] thr_wrn_lo_i,
   input  logic                    flag_clr_i,
   output logic [2*NUM_CH-1:0]     alm_flags_o,
   output logic [2*NUM_CH-1:0]     wrn_flags_o,
   output logic                    irq_o
);
   localparam int FLAG_W = 2 * NUM_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dmon_flag_gen: NUM_CH must be positive");
   end
   if (VAL_W % 8 != 0) begin : g_bad_bytes
      $error("dmon_flag_gen: VAL_W must be a whole number of bytes");
   end

   logic [FLAG_W-1:0] alm_viol, wrn_viol;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      dmon_chan #(.VAL_W(VAL_W), .IS_SIGNED(SIGNED_MASK[k])) u_chan (
         .val_i   (meas_i[k*VAL_W +: VAL_W]),
         .alm_hi_i(thr_alm_hi_i[k*VAL_W +: VAL_W]),
         .alm_lo_i(thr_alm_lo_i[k*VAL_W +: VAL_W]),
         .wrn_hi_i(thr_wrn_hi_i[k*VAL_W +: VAL_W]),
         .wrn_lo_i(thr_wrn_lo_i[k*VAL_W +: VAL_W]),
         .alm_o   (alm_viol[2*k +: 2]),
         .wrn_o   (wrn_viol[2*k +: 2])
      );
   end

   dmon_sticky #(.W(FLAG_W)) u_alm_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(meas_stb_i), .clr_i(flag_clr_i),
      .viol_i(alm_viol), .flags_o(alm_flags_o)
   );

   dmon_sticky #(.W(FLAG_W)) u_wrn_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(meas_stb_i), .clr_i(flag_clr_i),
      .viol_i(wrn_viol), .flags_o(wrn_flags_o)
   );

   assign irq_o = (|alm_flags_o) | (|wrn_flags_o);

   // R8: the interrupt can only rise after a strobed cycle
   a_r8_irq_needs_stb : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(meas_stb_i));

   // R8: a clear without strobe drops the interrupt
   a_r8_irq_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i && !meas_stb_i) |=> !irq_o);
endmodule

// File: tb/dmon_flag_gen_test.sv
module dmon_flag_gen_test;
   localparam int NCH = 5;
   localparam int VW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 1'b0;
   logic clr = 1'b0;
   logic [NCH*VW-1:0] meas, ahi, alo, whi, wlo;
   logic [2*NCH-1:0] alm, wrn;
   logic irq;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   dmon_flag_gen uut (
      .clk_i(clk), .rst_ni(rst_n), .meas_stb_i(stb), .meas_i(meas),
      .thr_alm_hi_i(ahi), .thr_alm_lo_i(alo), .thr_wrn_hi_i(whi),
      .thr_wrn_lo_i(wlo), .flag_clr_i(clr),
      .alm_flags_o(alm), .wrn_flags_o(wrn), .irq_o(irq)
   );

   // behavioural reference model
   logic [2*NCH-1:0] m_alm = '0;
   logic [2*NCH-1:0] m_wrn = '0;

   function automatic int as_int(input logic [15:0] x, input bit sgn);
      if (sgn && x[15]) return int'(x) - 65536;
      return int'(x);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_alm <= '0;
         m_wrn <= '0;
      end else begin
         logic [2*NCH-1:0] na, nw;
         na = clr ? '0 : m_alm;
         nw = clr ? '0 : m_wrn;
         if (stb) begin
            for (int k = 0; k < NCH; k++) begin
               int v;
               bit sg;
               sg = (k == 0);
               v = as_int(meas[k*VW +: VW], sg);
               if (v > as_int(ahi[k*VW +: VW], sg)) na[2*k] = 1'b1;
               if (v < as_int(alo[k*VW +: VW], sg)) na[2*k+1] = 1'b1;
               if (v > as_int(whi[k*VW +: VW], sg)) nw[2*k] = 1'b1;
               if (v < as_int(wlo[k*VW +: VW], sg)) nw[2*k+1] = 1'b1;
            end
         end
         m_alm <= na;
         m_wrn <= nw;
      end
   end

   // compare with model on every clock
   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (rst_n) begin
         checks++;
         if (alm !== m_alm || wrn !== m_wrn || irq !== ((|m_alm) | (|m_wrn))) begin
            fails++;
            $display("FAIL model R10 alm=%h wrn=%h irq=%b exp alm=%h wrn=%h", alm, wrn, irq, m_alm, m_wrn);
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_ch(input int k, input logic [15:0] v);
      meas[k*VW +: VW] = v;
   endtask

   task automatic nominal();
      set_ch(0, 16'd25);
      for (int k = 1; k < NCH; k++) set_ch(k, 16'd500);
   endtask

   // one cycle with the given strobe and clear; returns at a negedge after the edge
   task automatic step(input logic s, input logic c);
      @(negedge clk);
      stb = s;
      clr = c;
      @(negedge clk);
      stb = 1'b0;
      clr = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      for (int k = 0; k < NCH; k++) begin
         ahi[k*VW +: VW] = 16'd1000;
         whi[k*VW +: VW] = 16'd800;
         wlo[k*VW +: VW] = 16'd200;
         alo[k*VW +: VW] = 16'd100;
      end
      ahi[0 +: VW] = 16'd70;
      whi[0 +: VW] = 16'd60;
      wlo[0 +: VW] = 16'hFFFB;  // -5
      alo[0 +: VW] = 16'hFFF6;  // -10
      nominal();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset alm", 32'(alm), 32'h0);
      check("R9 reset wrn", 32'(wrn), 32'h0);
      check("R9 reset irq", 32'(irq), 32'h0);

      step(1'b1, 1'b0);
      check("R8 nominal irq low", 32'(irq), 32'h0);

      // R1 R3: supply exactly on alarm limit, above warning
      set_ch(1, 16'd1000);
      step(1'b1, 1'b0);
      check("R1 equal to upper alarm limit", 32'(alm), 32'h0);
      check("R3 warning only", 32'(wrn), 32'h004);
      check("R8 irq set", 32'(irq), 32'h1);

      nominal();
      step(1'b0, 1'b1);
      check("R7 clear alm", 32'(alm), 32'h0);
      check("R7 clear wrn", 32'(wrn), 32'h0);
      check("R8 irq after clear", 32'(irq), 32'h0);

      // R1 R10: bias one past alarm limit
      set_ch(2, 16'd1001);
      step(1'b1, 1'b0);
      check("R1 upper alarm bias", 32'(alm), 32'h010);
      check("R3 upper warning bias", 32'(wrn), 32'h010);
      nominal();
      step(1'b1, 1'b0);
      check("R6 sticky alm", 32'(alm), 32'h010);
      check("R6 sticky wrn", 32'(wrn), 32'h010);
      step(1'b0, 1'b1);

      // R2 R10: two lower conditions at once
      set_ch(3, 16'd50);
      set_ch(4, 16'd150);
      step(1'b1, 1'b0);
      check("R2 lower alarm txpwr", 32'(alm), 32'h080);
      check("R10 multiple warnings", 32'(wrn), 32'h280);
      nominal();
      set_ch(4, 16'd100);
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      check("R2 equal to lower alarm limit", 32'(alm), 32'h0);
      check("R2 lower warning only", 32'(wrn), 32'h200);
      nominal();
      step(1'b0, 1'b1);

      // R5: violations without strobe
      set_ch(0, 16'd500);
      set_ch(2, 16'd5);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      check("R5 no strobe alm", 32'(alm), 32'h0);
      check("R5 no strobe wrn", 32'(wrn), 32'h0);
      nominal();

      // R4: temperature signed
      set_ch(0, 16'hFFF5);
      step(1'b1, 1'b0);
      check("R4 signed temp alm", 32'(alm), 32'h002);
      check("R4 signed temp wrn", 32'(wrn), 32'h002);
      // R7: clear coincides with violation
      step(1'b1, 1'b1);
      check("R7 clear vs new violation", 32'(alm), 32'h002);
      nominal();
      step(1'b0, 1'b1);

      // R4: receive power unsigned
      set_ch(4, 16'hFFFF);
      step(1'b1, 1'b0);
      check("R4 unsigned rxpwr alm", 32'(alm), 32'h100);
      check("R4 unsigned rxpwr wrn", 32'(wrn), 32'h100);
      nominal();
      step(1'b0, 1'b1);
      check("R8 irq final clear", 32'(irq), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      while (!done && cycles < 5000) @(negedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule